// File: doc/BRIEF.md
# Voice-Band Codec Interface Sequencer

This block is the digital side of a voice-band converter link inside a signal processor. Software configures it through a data-memory bus: a control word whose two power bits switch the interface on, an autobuffer word, a receive register that holds the latest converter input sample, and a transmit register that holds the next output sample. While powered, a frame timer divides the processor clock so that one 16-bit word moves in each direction per frame. With the default 1625-cycle frame and a 13 MHz clock, this gives 8 kHz. Gain, multiplexer and filter fields in the control word are stored and read back, but they have no effect inside the block.

On each frame the receive register captures the converter input, and the transmit register is presented on the converter output. In plain mode, each frame raises a receive interrupt and a transmit interrupt. Reading the receive register clears the receive interrupt, and writing the transmit register clears the transmit interrupt. In autobuffer mode, a small sequencer stores each received word into a ring in on-chip memory, or fetches the next transmit word from a second ring, or both. In this mode an interrupt is raised only when a ring index wraps.

The sequencer has four states. OFF is the powered-down state. COUNT waits for a frame. STORE writes the received word to memory. FETCH reads the next transmit word. Transitions:
- OFF→COUNT when both power bits are 1.
- COUNT→STORE on a frame with receive autobuffer on.
- COUNT→FETCH on a frame with only transmit autobuffer on.
- STORE→FETCH when transmit autobuffer is on, otherwise STORE→COUNT.
- FETCH→COUNT.
- Any state→OFF when either power bit is 0.

Top module: `codec_if_ctrl`

## Requirements
- R1: After reset the control word (address 0x3FEE) reads 0x0000, and both interrupts and the frame strobe are low.
- R2: Bits 15:10 of the control word always read 0; a write of 0xFF9F reads back as 0x039F.
- R3: Unless control bits 5 and 6 are both 1, no frame strobe, memory access or new interrupt occurs, however long the bus waits.
- R4: The first frame strobe comes exactly FRAME_LEN cycles after the edge that sets both power bits. Later strobes follow every FRAME_LEN cycles.
- R5: On a frame, the converter input word is captured into the receive register (0x3FED). Without receive autobuffer, `irq_rx` rises on the next edge. A bus read of 0x3FED clears it.
- R6: On a frame, the transmit register (0x3FEC) content appears on `dac_word`. Without transmit autobuffer, `irq_tx` rises on the next edge. A bus write of 0x3FEC clears it.
- R7: With autobuffer bit 0 of address 0x3FEF set, the cycle after each frame writes the received word to RX_BASE+index. The index steps modulo BUF_LEN, and `irq_rx` is raised only when it wraps.
- R8: With autobuffer bit 1 set, a memory read of TX_BASE+index follows each frame (after the store, if any) and loads the transmit register. The index steps modulo BUF_LEN, and `irq_tx` is raised only when it wraps.
- R9: Clearing a power bit returns the interface to OFF. The frame timer restarts from zero, and no further strobes occur.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 14 | Data-memory address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, same cycle |
| adc_word | input | 16 | Converter input sample |
| dac_word | output | 16 | Converter output sample |
| frame_strobe | output | 1 | One-cycle frame pulse |
| mem_req | output | 1 | Autobuffer memory access |
| mem_we | output | 1 | Autobuffer write (1) or read (0) |
| mem_addr | output | 14 | Autobuffer memory address |
| mem_wdata | output | 16 | Autobuffer write data |
| mem_rdata | input | 16 | Autobuffer read data, same cycle |
| irq_rx | output | 1 | Receive interrupt |
| irq_tx | output | 1 | Transmit interrupt |

## Verification
The frame strobe is high during the cycle in which the timer reads FRAME_LEN-1. The receive capture, the transmit output and the plain-mode interrupts appear one edge later. The autobuffer store is driven in the cycle after the frame, and the fetch follows in the next cycle, so its data reaches the transmit register two edges after the frame. The bench waits for the strobe at a falling edge and then steps a fixed number of falling edges (one for frame results, two more for autobuffer results) before sampling. Memory writes are logged at every falling edge, so their address and data are compared cycle-exactly.

// File: rtl/codec_if_pkg.sv
package codec_if_pkg;
    localparam int WORD_W = 16;
    localparam int ADDR_W = 14;

    localparam logic [ADDR_W-1:0] ADDR_DAC  = 14'h3FEC;
    localparam logic [ADDR_W-1:0] ADDR_ADC  = 14'h3FED;
    localparam logic [ADDR_W-1:0] ADDR_CTRL = 14'h3FEE;
    localparam logic [ADDR_W-1:0] ADDR_ABUF = 14'h3FEF;

    localparam int PWR_BIT_LO = 5;
    localparam int PWR_BIT_HI = 6;
    localparam logic [WORD_W-1:0] CTRL_KEEP = 16'h03FF;

    typedef enum logic [1:0] {
        S_OFF,
        S_COUNT,
        S_STORE,
        S_FETCH
    } seq_state_t;
endpackage

// File: rtl/codec_frame_timer.sv
module codec_frame_timer #(
    parameter int FRAME_LEN = 1625
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic strobe
);
    localparam int CW = (FRAME_LEN > 1) ? $clog2(FRAME_LEN) : 1;
    localparam logic [CW-1:0] LAST = CW'(FRAME_LEN - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign strobe = run && (cnt_q == LAST);

    // R4: the count never leaves its frame range
    a_r4_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

    // R9: powering down restarts the frame from zero
    a_r9_off_clears_count: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> cnt_q == '0);
endmodule

// File: rtl/codec_abuf_index.sv
module codec_abuf_index #(
    parameter int                BUF_LEN = 4,
    parameter int                ADDR_W  = 14,
    parameter logic [ADDR_W-1:0] BASE    = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              step,
    output logic [ADDR_W-1:0] addr,
    output logic              wrap
);
    localparam int IW = (BUF_LEN > 1) ? $clog2(BUF_LEN) : 1;
    localparam logic [IW-1:0] LAST = IW'(BUF_LEN - 1);

    logic [IW-1:0] idx_q;

    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            idx_q <= '0;
        end else if (step) begin
            idx_q <= (idx_q == LAST) ? '0 : idx_q + 1'b1;
        end
    end

    assign addr = BASE + ADDR_W'(idx_q);
    assign wrap = step && (idx_q == LAST);

    // R7 / R8: ring index stays inside the buffer
    a_r7_index_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        idx_q <= LAST);
endmodule

// File: rtl/codec_if_ctrl.sv
module codec_if_ctrl
    import codec_if_pkg::*;
#(
    parameter int                FRAME_LEN = 1625,
    parameter int                BUF_LEN   = 4,
    parameter logic [ADDR_W-1:0] RX_BASE   = 14'h0100,
    parameter logic [ADDR_W-1:0] TX_BASE   = 14'h0200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    input  logic [WORD_W-1:0] adc_word,
    output logic [WORD_W-1:0] dac_word,
    output logic              frame_strobe,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              irq_rx,
    output logic              irq_tx
);
    seq_state_t        state_q, state_d;
    logic [WORD_W-1:0] ctrl_q, adc_q, dac_q, dac_out_q;
    logic [1:0]        abuf_q;
    logic              rx_pend_q, tx_pend_q;
    logic              pwr_on, bus_wr, bus_rd, cfg_wr;
    logic              rx_step, tx_step, rx_wrap, tx_wrap;
    logic [ADDR_W-1:0] rx_addr, tx_addr;

    assign pwr_on = ctrl_q[PWR_BIT_LO] && ctrl_q[PWR_BIT_HI];
    assign bus_wr = bus_en && bus_we;
    assign bus_rd = bus_en && !bus_we;
    assign cfg_wr = bus_wr && (bus_addr == ADDR_CTRL || bus_addr == ADDR_ABUF);

    codec_frame_timer #(.FRAME_LEN(FRAME_LEN)) i_timer (
        .clk(clk), .rst_n(rst_n), .run(pwr_on), .strobe(frame_strobe)
    );

    codec_abuf_index #(.BUF_LEN(BUF_LEN), .ADDR_W(ADDR_W), .BASE(RX_BASE)) i_rx_ring (
        .clk(clk), .rst_n(rst_n), .enable(abuf_q[0]), .step(rx_step),
        .addr(rx_addr), .wrap(rx_wrap)
    );

    codec_abuf_index #(.BUF_LEN(BUF_LEN), .ADDR_W(ADDR_W), .BASE(TX_BASE)) i_tx_ring (
        .clk(clk), .rst_n(rst_n), .enable(abuf_q[1]), .step(tx_step),
        .addr(tx_addr), .wrap(tx_wrap)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_OFF;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_OFF:   if (pwr_on) state_d = S_COUNT;
            S_COUNT: begin
                if (!pwr_on)                       state_d = S_OFF;
                else if (frame_strobe && abuf_q[0]) state_d = S_STORE;
                else if (frame_strobe && abuf_q[1]) state_d = S_FETCH;
            end
            S_STORE: begin
                if (!pwr_on)        state_d = S_OFF;
                else if (abuf_q[1]) state_d = S_FETCH;
                else                state_d = S_COUNT;
            end
            S_FETCH: state_d = pwr_on ? S_COUNT : S_OFF;
            default: state_d = S_OFF;
        endcase
    end

    // state outputs
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        rx_step   = 1'b0;
        tx_step   = 1'b0;
        unique case (state_q)
            S_STORE: if (pwr_on) begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = rx_addr;
                mem_wdata = adc_q;
                rx_step   = 1'b1;
            end
            S_FETCH: if (pwr_on) begin
                mem_req  = 1'b1;
                mem_addr = tx_addr;
                tx_step  = 1'b1;
            end
            default: ;
        endcase
    end

    // registers seen by the bus and the converter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q    <= '0;
            abuf_q    <= '0;
            adc_q     <= '0;
            dac_q     <= '0;
            dac_out_q <= '0;
            rx_pend_q <= 1'b0;
            tx_pend_q <= 1'b0;
        end else begin
            if (bus_wr && bus_addr == ADDR_CTRL) ctrl_q <= bus_wdata & CTRL_KEEP;
            if (bus_wr && bus_addr == ADDR_ABUF) abuf_q <= bus_wdata[1:0];
            if (frame_strobe) begin
                adc_q     <= adc_word;
                dac_out_q <= dac_q;
            end
            if (tx_step)                             dac_q <= mem_rdata;
            else if (bus_wr && bus_addr == ADDR_DAC) dac_q <= bus_wdata;

            if ((frame_strobe && !abuf_q[0]) || rx_wrap) rx_pend_q <= 1'b1;
            else if (bus_rd && bus_addr == ADDR_ADC)     rx_pend_q <= 1'b0;

            if ((frame_strobe && !abuf_q[1]) || tx_wrap) tx_pend_q <= 1'b1;
            else if (bus_wr && bus_addr == ADDR_DAC)     tx_pend_q <= 1'b0;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            case (bus_addr)
                ADDR_CTRL: bus_rdata = ctrl_q;
                ADDR_ABUF: bus_rdata = {{(WORD_W-2){1'b0}}, abuf_q};
                ADDR_ADC:  bus_rdata = adc_q;
                ADDR_DAC:  bus_rdata = dac_q;
                default:   bus_rdata = '0;
            endcase
        end
    end

    assign dac_word = dac_out_q;
    assign irq_rx   = rx_pend_q;
    assign irq_tx   = tx_pend_q;

    // R2: reserved control bits never read back
    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_CTRL) |-> bus_rdata[15:10] == '0);

    // R3: no strobe while powered down
    a_r3_off_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_on |-> !frame_strobe && !mem_req);

    // R3: no new interrupt follows a powered-down cycle
    a_r3_off_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_on |=> !$rose(irq_rx) && !$rose(irq_tx));

    // R5: plain receive frame raises its interrupt
    a_r5_rx_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_strobe && !abuf_q[0]) |=> irq_rx);

    // R6: plain transmit frame raises its interrupt
    a_r6_tx_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_strobe && !abuf_q[1]) |=> irq_tx);

    // R7: a receive-autobuffer frame is followed by a memory write
    a_r7_store_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_strobe && abuf_q[0] && !cfg_wr) |=> mem_req && mem_we);

    // R8: a store with transmit autobuffer on is followed by a read
    a_r8_fetch_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && abuf_q[1] && !cfg_wr) |=> mem_req && !mem_we);

    // R9: losing power lands the sequencer in OFF
    a_r9_fall_to_off: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pwr_on) |-> state_q != S_STORE || !mem_req);
endmodule

// File: tb/test_codec_if_ctrl.sv
`timescale 1ns/1ps
module test_codec_if_ctrl;
    localparam int FL = 1625;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0, bus_we = 1'b0;
    logic [13:0] bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [15:0] adc_word = '0;
    logic [15:0] dac_word;
    logic        frame_strobe, mem_req, mem_we, irq_rx, irq_tx;
    logic [13:0] mem_addr;
    logic [15:0] mem_wdata, mem_rdata;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    logic [13:0] log_addr [8];
    logic [15:0] log_data [8];
    int          log_n = 0;

    always #2.5 clk = ~clk;

    assign mem_rdata = 16'hA000 ^ {2'b00, mem_addr};

    codec_if_ctrl i_codec_if_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .adc_word(adc_word), .dac_word(dac_word), .frame_strobe(frame_strobe),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .irq_rx(irq_rx), .irq_tx(irq_tx)
    );

    always @(negedge clk) begin
        if (mem_req && mem_we && log_n < 8) begin
            log_addr[log_n] = mem_addr;
            log_data[log_n] = mem_wdata;
            log_n++;
        end
    end

    // plain-mode vectors: {adc input, dac word}
    localparam logic [31:0] VEC [4] = '{
        32'h1234_8001, 32'hFFFF_0000, 32'h0000_FFFF, 32'hA5A5_5A5A
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [13:0] a, input logic [15:0] d);
        bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 0; bus_we = 0;
    endtask

    task automatic bus_read(input logic [13:0] a, output logic [15:0] d);
        bus_en = 1; bus_we = 0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_en = 0;
    endtask

    task automatic wait_frame();
        int g = 0;
        while (!frame_strobe && g < 4000) begin
            @(negedge clk);
            g++;
        end
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            report();
        end
    end

    initial begin
        logic [15:0] rd;
        int n, strobes;
        @(negedge clk);
        do_reset();

        // R1: reset state
        bus_read(14'h3FEE, rd);
        chk(rd == 16'h0000, "R1 ctrl", rd, 16'h0000);
        chk(!irq_rx && !irq_tx && !frame_strobe, "R1 outputs", {irq_rx, irq_tx, frame_strobe}, 0);

        // R2: reserved bits
        bus_write(14'h3FEE, 16'hFF9F);
        bus_read(14'h3FEE, rd);
        chk(rd == 16'h039F, "R2 reserved", rd, 16'h039F);

        // R3: one power bit only
        bus_write(14'h3FEE, 16'h0040);
        strobes = 0;
        for (int k = 0; k < 1800; k++) begin
            @(negedge clk);
            if (frame_strobe || mem_req) strobes++;
        end
        chk(strobes == 0, "R3 bit6 only", strobes, 0);
        chk(!irq_rx && !irq_tx, "R3 irq", {irq_rx, irq_tx}, 0);

        // R4: first strobe and period
        bus_write(14'h3FEE, 16'h0060);
        n = 1;
        while (!frame_strobe && n < 4000) begin
            @(negedge clk);
            n++;
        end
        chk(n == FL, "R4 first", n, FL);
        @(negedge clk);
        n = 1;
        while (!frame_strobe && n < 4000) begin
            @(negedge clk);
            n++;
        end
        chk(n == FL, "R4 period", n, FL);
        @(negedge clk);

        // R5 / R6: plain frames from vector table
        foreach (VEC[i]) begin
            bus_write(14'h3FEC, VEC[i][15:0]);
            chk(!irq_tx, "R6 clear on write", irq_tx, 0);
            adc_word = VEC[i][31:16];
            wait_frame();
            chk(dac_word == VEC[i][15:0], "R6 dac out", dac_word, VEC[i][15:0]);
            chk(irq_tx && irq_rx, "R5 R6 irq", {irq_rx, irq_tx}, 2'b11);
            bus_read(14'h3FED, rd);
            chk(rd == VEC[i][31:16], "R5 adc capture", rd, VEC[i][31:16]);
            chk(!irq_rx, "R5 clear on read", irq_rx, 0);
        end

        // R7 / R8: autobuffer both directions
        do_reset();
        log_n = 0;
        bus_write(14'h3FEF, 16'h0003);
        bus_write(14'h3FEE, 16'h0060);
        for (int f = 1; f <= 5; f++) begin
            adc_word = 16'h1110 + 16'(f);
            wait_frame();
            repeat (2) @(negedge clk);
            chk(log_n == f, "R7 store count", log_n, f);
            chk(log_addr[f-1] == 14'h0100 + 14'((f-1) % 4), "R7 store addr",
                log_addr[f-1], 14'h0100 + 14'((f-1) % 4));
            chk(log_data[f-1] == 16'h1110 + 16'(f), "R7 store data",
                log_data[f-1], 16'h1110 + 16'(f));
            chk(irq_rx == (f >= 4), "R7 wrap irq", irq_rx, (f >= 4));
            chk(irq_tx == (f >= 4), "R8 wrap irq", irq_tx, (f >= 4));
            bus_read(14'h3FEC, rd);
            chk(rd == (16'hA000 ^ (16'h0200 + 16'((f-1) % 4))), "R8 fetch",
                rd, 16'hA000 ^ (16'h0200 + 16'((f-1) % 4)));
            if (f == 1)
                chk(dac_word == 16'h0000, "R8 dac first", dac_word, 0);
            else
                chk(dac_word == (16'hA000 ^ (16'h0200 + 16'((f-2) % 4))), "R8 dac out",
                    dac_word, 16'hA000 ^ (16'h0200 + 16'((f-2) % 4)));
        end

        // R9: power down stops framing
        bus_write(14'h3FEE, 16'h0020);
        strobes = 0;
        for (int k = 0; k < 2000; k++) begin
            @(negedge clk);
            if (frame_strobe || mem_req) strobes++;
        end
        chk(strobes == 0, "R9 stopped", strobes, 0);

        done = 1;
        report();
    end
endmodule